// File: doc/BRIEF.md
# Split-Opcode 8-bit Arithmetic-Logic Unit

This block computes one arithmetic or bitwise result from two 8-bit operands under a 4-bit opcode. It also reports four status flags. The most significant opcode bit picks the unit. When that bit is clear, an adder/subtractor runs one of four variants, chosen by the two lowest opcode bits. When it is set, a bitwise unit runs one of eight functions, chosen by the three lowest opcode bits. Each flag is defined only for certain operation classes and reads 0 for all others. The zero flag is the exception: it follows the result for every opcode.

The combinational core takes a one-bit carry input. The top level wraps the core with three registers: one for each operand and one for the carry. On a load pulse, the operand registers capture new values. On the same edge, the carry register captures the raw carry-out of the operation that was being computed. That carry then feeds the next operation, so multi-byte additions and subtractions can be chained one byte per load. The opcode is not registered. Changing it changes the result and flags in the same cycle.

Top module: `alu8_top`

## Requirements
- R1: With `op[3]`=0, `op[1:0]`=00 gives A+B+c and `op[1:0]`=01 gives A+~B+c, each modulo 256, where c is the stored carry.
- R2: With `op[3]`=0, `op[1:0]`=10 gives A+B with carry-in fixed at 0, and `op[1:0]`=11 gives A+~B+1 (that is, A−B), ignoring the stored carry.
- R3: In the arithmetic unit, `op[2]` has no effect: opcodes 0100–0111 give the same result and flags as 0000–0011.
- R4: With `op[3]`=1, `op[2:0]` selects the function: 000 A^B, 001 ~A, 010 A&B, 011 A|B, 100 ~(A&B), 101 A unchanged, 110 ~(A^B), 111 ~(A|B).
- R5: The zero flag, `status[2]`, is 1 exactly when `result` is 8'h00, for every opcode.
- R6: The carry flag, `status[0]`, equals the carry out of bit 7 for opcodes x000 and x010 (op[3]=0). For every other opcode it is 0.
- R7: The overflow flag, `status[3]`, is 1 only for opcodes x010 (op[3]=0), when both operands have the same sign and the result's sign differs. For all other cases it is 0.
- R8: The negative flag, `status[1]`, equals `result[7]` for the subtract opcodes x001 and x011 (op[3]=0). For every other opcode it is 0.
- R9: The status word is packed {overflow, zero, negative, carry} in bits 3 down to 0.
- R10: On a rising edge with `ld_en`=1, the operand registers capture `a_in` and `b_in`. With `ld_en`=0, they hold, and `result` does not change while `op` is unchanged.
- R11: On each load edge, the carry register captures the adder's raw carry-out for the opcode applied at that edge. This holds for subtracts too, where the raw carry means "no borrow". After a bitwise opcode it captures 0.
- R12: A synchronous reset (`rst`=1 at a rising edge) clears both operand registers and the carry register to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | Load strobe for operand and carry registers |
| a_in | input | 8 | Operand A to be loaded |
| b_in | input | 8 | Operand B to be loaded |
| op | input | 4 | Opcode; bit 3 picks the unit |
| result | output | 8 | Result of the operation on the registered operands |
| status | output | 4 | {overflow, zero, negative, carry} |

## Verification
The operand and carry registers are the only state. `result` and `status` are therefore due in the same cycle as the load edge that captured the operands, and an opcode change shows up at once, with no edge needed. The bench drives operands and `ld_en` on the falling edge and drives the opcode after the load edge. It samples one nanosecond before the next rising edge, so every result it reads comes from exactly one settled register state. The carry used by each check is predicted from the opcode that was present at the preceding load edge. For the hold check, a full clock edge passes with `ld_en` low before the sample.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DATA_W = 8;
    localparam int OP_W   = 4;

    // arithmetic variant, decoded from opcode bits [1:0]
    typedef enum logic [1:0] {
        AR_ADDC = 2'b00,
        AR_SUBC = 2'b01,
        AR_ADDV = 2'b10,
        AR_SUBV = 2'b11
    } arith_sel_e;

    // bitwise variant, decoded from opcode bits [2:0]
    typedef enum logic [2:0] {
        LG_XOR  = 3'b000,
        LG_INV  = 3'b001,
        LG_AND  = 3'b010,
        LG_OR   = 3'b011,
        LG_NAND = 3'b100,
        LG_PASS = 3'b101,
        LG_XNOR = 3'b110,
        LG_NOR  = 3'b111
    } logic_sel_e;

    typedef struct packed {
        logic ovf;
        logic zero;
        logic neg;
        logic cry;
    } status_t;

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
    import alu8_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  arith_sel_e   sel_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         ovf_o,
    output logic         neg_o,
    output logic         cry_o
);

    logic [W-1:0] b_eff;
    logic         c_first;
    logic [W:0]   chain;

    // operand inversion and carry-in source per variant
    always_comb begin
        unique case (sel_i)
            AR_ADDC: begin b_eff = b_i;  c_first = cin_i; end
            AR_SUBC: begin b_eff = ~b_i; c_first = cin_i; end
            AR_ADDV: begin b_eff = b_i;  c_first = 1'b0;  end
            AR_SUBV: begin b_eff = ~b_i; c_first = 1'b1;  end
            default: begin b_eff = b_i;  c_first = 1'b0;  end
        endcase
    end

    assign chain[0] = c_first;

    // ripple chain, one full-adder slice per bit
    for (genvar i = 0; i < W; i++) begin : g_slice
        assign sum_o[i]   = a_i[i] ^ b_eff[i] ^ chain[i];
        assign chain[i+1] = (a_i[i] & b_eff[i]) | (chain[i] & (a_i[i] ^ b_eff[i]));
    end

    assign cout_o = chain[W];

    // class-qualified flags
    always_comb begin
        ovf_o = 1'b0;
        neg_o = 1'b0;
        cry_o = 1'b0;
        unique case (sel_i)
            AR_ADDC: cry_o = chain[W];
            AR_SUBC: neg_o = sum_o[W-1];
            AR_ADDV: begin
                cry_o = chain[W];
                ovf_o = chain[W] ^ chain[W-1];
            end
            AR_SUBV: neg_o = sum_o[W-1];
            default: ;
        endcase
    end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic_sel_e   sel_i,
    output logic [W-1:0] y_o
);

    function automatic logic bit_fn(input logic_sel_e s, input logic x, input logic y);
        logic r;
        unique case (s)
            LG_XOR:  r = x ^ y;
            LG_INV:  r = ~x;
            LG_AND:  r = x & y;
            LG_OR:   r = x | y;
            LG_NAND: r = ~(x & y);
            LG_PASS: r = x;
            LG_XNOR: r = ~(x ^ y);
            LG_NOR:  r = ~(x | y);
            default: r = 1'b0;
        endcase
        return r;
    endfunction

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign y_o[i] = bit_fn(sel_i, a_i[i], b_i[i]);
    end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0]    a_i,
    input  logic [W-1:0]    b_i,
    input  logic [OP_W-1:0] op_i,
    input  logic            st_i,
    output logic [W-1:0]    res_o,
    output status_t         st_o,
    output logic            craw_o
);

    logic [W-1:0] ar_sum, lg_y;
    logic         ar_cout, ar_ovf, ar_neg, ar_cry;
    logic         use_logic;

    assign use_logic = op_i[OP_W-1];

    alu8_arith #(.W(W)) u_arith (
        .a_i    (a_i),
        .b_i    (b_i),
        .sel_i  (arith_sel_e'(op_i[1:0])),
        .cin_i  (st_i),
        .sum_o  (ar_sum),
        .cout_o (ar_cout),
        .ovf_o  (ar_ovf),
        .neg_o  (ar_neg),
        .cry_o  (ar_cry)
    );

    alu8_logic #(.W(W)) u_logic (
        .a_i   (a_i),
        .b_i   (b_i),
        .sel_i (logic_sel_e'(op_i[2:0])),
        .y_o   (lg_y)
    );

    always_comb begin
        if (use_logic) begin
            res_o    = lg_y;
            st_o.ovf = 1'b0;
            st_o.neg = 1'b0;
            st_o.cry = 1'b0;
            craw_o   = 1'b0;
        end else begin
            res_o    = ar_sum;
            st_o.ovf = ar_ovf;
            st_o.neg = ar_neg;
            st_o.cry = ar_cry;
            craw_o   = ar_cout;
        end
        st_o.zero = ~|res_o;
    end

endmodule

// File: rtl/alu8_top.sv
module alu8_top
    import alu8_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ld_en,
    input  logic [W-1:0]    a_in,
    input  logic [W-1:0]    b_in,
    input  logic [OP_W-1:0] op,
    output logic [W-1:0]    result,
    output logic [3:0]      status
);

    logic [W-1:0] a_q, b_q;
    logic         c_q;
    logic         c_raw;
    status_t      st;

    // operand and carry registers
    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= '0;
            b_q <= '0;
            c_q <= 1'b0;
        end else if (ld_en) begin
            a_q <= a_in;
            b_q <= b_in;
            c_q <= c_raw;
        end
    end

    alu8_core #(.W(W)) u_core (
        .a_i    (a_q),
        .b_i    (b_q),
        .op_i   (op),
        .st_i   (c_q),
        .res_o  (result),
        .st_o   (st),
        .craw_o (c_raw)
    );

    assign status = st;

endmodule

// File: rtl/alu8_chk.sv
module alu8_chk
    import alu8_pkg::*;
#(
    parameter int W = DATA_W
) (
    input logic            clk,
    input logic            rst,
    input logic            ld_en,
    input logic [OP_W-1:0] op,
    input logic [W-1:0]    result,
    input logic [3:0]      status
);

    // R6: carry flag silent outside the two add opcodes
    a_r6_carry_add_only: assert property (@(posedge clk) disable iff (rst)
        (op[3] || op[0]) |-> !status[0]);

    // R7: overflow flag silent outside signed add
    a_r7_ovf_addv_only: assert property (@(posedge clk) disable iff (rst)
        (op[3] || op[1:0] != 2'b10) |-> !status[3]);

    // R8: negative flag silent outside subtracts
    a_r8_neg_sub_only: assert property (@(posedge clk) disable iff (rst)
        (op[3] || !op[0]) |-> !status[1]);

    // R10: no load and same opcode keeps the result
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        !ld_en ##1 $stable(op) |-> $stable(result));

    // R12: cleared registers cannot produce carry or overflow
    a_r12_reset_clear: assert property (@(posedge clk)
        rst |=> (!status[0] && !status[3]));

endmodule

bind alu8_top alu8_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .ld_en  (ld_en),
    .op     (op),
    .result (result),
    .status (status)
);

// File: tb/sim_alu8_top.sv
module sim_alu8_top;

    localparam int CLK_NS = 4;
    localparam int NV     = 17;

    // {a, b, op}
    localparam logic [19:0] VEC [NV] = '{
        {8'h3A, 8'hC5, 4'h0},
        {8'h80, 8'h80, 4'h2},
        {8'h7F, 8'h01, 4'h2},
        {8'h10, 8'h20, 4'h3},
        {8'h20, 8'h10, 4'h3},
        {8'h55, 8'h55, 4'h1},
        {8'hF0, 8'h0F, 4'h8},
        {8'hF0, 8'h0F, 4'h9},
        {8'hCC, 8'hAA, 4'hA},
        {8'hCC, 8'hAA, 4'hB},
        {8'hCC, 8'hAA, 4'hC},
        {8'h3C, 8'hFF, 4'hD},
        {8'hCC, 8'hAA, 4'hE},
        {8'h00, 8'h00, 4'hF},
        {8'hFF, 8'hFF, 4'hF},
        {8'hFF, 8'h01, 4'h0},
        {8'h44, 8'h33, 4'h6}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ld_en = 1'b0;
    logic [7:0] a_in = '0, b_in = '0;
    logic [3:0] op = '0;
    logic [7:0] result;
    logic [3:0] status;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 0;

    logic [7:0] am = '0, bm = '0;
    logic       cm = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    alu8_top u0 (
        .clk(clk), .rst(rst), .ld_en(ld_en),
        .a_in(a_in), .b_in(b_in), .op(op),
        .result(result), .status(status)
    );

    // returns {raw carry, status[3:0], result[7:0]}
    function automatic logic [12:0] model(input logic [7:0] a, input logic [7:0] b,
                                          input logic [3:0] o, input logic c);
        logic [8:0] s;
        logic [7:0] r, bb;
        logic v, n, cf, raw, ci;
        v = 0; n = 0; cf = 0; raw = 0; r = '0;
        if (!o[3]) begin
            bb  = o[0] ? ~b : b;
            ci  = o[1] ? o[0] : c;
            s   = {1'b0, a} + {1'b0, bb} + {8'b0, ci};
            r   = s[7:0];
            raw = s[8];
            cf  = !o[0] && raw;
            v   = (o[1:0] == 2'b10) && (a[7] == b[7]) && (r[7] != a[7]);
            n   = o[0] && r[7];
        end else begin
            case (o[2:0])
                3'd0: r = a ^ b;
                3'd1: r = ~a;
                3'd2: r = a & b;
                3'd3: r = a | b;
                3'd4: r = ~(a & b);
                3'd5: r = a;
                3'd6: r = ~(a ^ b);
                default: r = ~(a | b);
            endcase
        end
        return {raw, v, (r == 8'h00), n, cf, r};
    endfunction

    task automatic check(input string tag, input logic [11:0] got, input logic [11:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got res=%h st=%b, expected res=%h st=%b",
                     tag, got[7:0], got[11:8], exp[7:0], exp[11:8]);
        end
    endtask

    // load operands at the next edge; the carry captured follows the opcode held there
    task automatic load(input logic [7:0] a, input logic [7:0] b);
        logic [12:0] m;
        @(negedge clk);
        a_in = a; b_in = b; ld_en = 1'b1;
        m  = model(am, bm, op, cm);
        cm = m[12];
        am = a; bm = b;
        @(posedge clk);
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic sample(input string tag, input logic [11:0] exp);
        #1;
        check(tag, {status, result}, exp);
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        #(CLK_NS * 150000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog (all requirements): got timeout, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [12:0] m;
        // R12: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        sample("R12 reset state", {4'b0100, 8'h00});

        // R11 / R6: carry chain across loads with ADDC
        op = 4'h0;
        load(8'hFF, 8'h01);
        sample("R6 ADDC carry out", {4'b0101, 8'h00});
        load(8'h00, 8'h00);
        sample("R11 carry fed back", {4'b0000, 8'h01});
        load(8'h00, 8'h00);
        sample("R11 carry consumed", {4'b0100, 8'h00});

        // R10: no load, inputs change, result holds
        @(negedge clk);
        a_in = 8'hAA; b_in = 8'h55;
        @(posedge clk); @(negedge clk);
        sample("R10 hold without load", {4'b0100, 8'h00});

        // R3: op[2] aliasing in arithmetic unit
        load(8'h44, 8'h33);
        op = 4'h3;
        sample("R2 SUBO 44-33", {4'b0000, 8'h11});
        op = 4'h7;
        sample("R3 alias 0111", {4'b0000, 8'h11});
        op = 4'h2; #1;
        op = 4'h6;
        sample("R3 alias 0110", {4'b0000, 8'h77});

        // R7 / R9: signed overflow packing
        op = 4'h2;
        load(8'h7F, 8'h01);
        sample("R7 R9 overflow bit 3", {4'b1000, 8'h80});

        // R8: borrow result sets negative
        op = 4'h3;
        load(8'h05, 8'h07);
        sample("R8 negative on SUBO", {4'b0010, 8'hFE});

        // R11: subtract raw carry then bitwise opcode captures 0
        op = 4'h3;
        load(8'h00, 8'h00);  // captured raw carry of 05-07 = 0 (borrow)
        op = 4'h1;
        sample("R11 SUBC after borrow", {4'b0010, 8'hFF});
        op = 4'h8;
        load(8'h10, 8'h10);  // captured with bitwise opcode -> 0
        op = 4'h0;
        sample("R11 carry after logic op", {4'b0000, 8'h20});

        // table walk: R1 R2 R4 R5
        for (int i = 0; i < NV; i++) begin
            load(VEC[i][19:12], VEC[i][11:4]);
            op = VEC[i][3:0];
            #1;
            m = model(am, bm, op, cm);
            check(op[3] ? "R4 R5 logic vector" : (op[1] ? "R2 R5 fixed-carry vector" : "R1 R5 carry vector"),
                  {status, result}, m[11:0]);
        end

        // R12: reset mid-run clears operands and carry
        op = 4'h0;
        load(8'hFF, 8'h01);
        load(8'h12, 8'h34);  // carry register now 1
        @(negedge clk); rst = 1'b1;
        @(posedge clk); @(negedge clk); rst = 1'b0;
        op = 4'h8;
        sample("R12 mid-run reset operands", {4'b0100, 8'h00});
        op = 4'h0;
        sample("R12 mid-run reset carry", {4'b0100, 8'h00});

        done = 1;
        summary();
        $finish;
    end

endmodule